// File: doc/BRIEF.md
# Common-IO Synchronous SRAM Core

A clocked single-port memory whose write data and read data travel over one shared bidirectional bus. Each 36-bit word is split into four lanes, and each lane holds one 8-bit data byte plus one parity bit. Data byte `i` sits on `dq[8i+7:8i]` and its parity bit sits on `dq[32+i]`. Every lane has its own active-low write strobe, so a controller can update part of a word without reading it back first.

A command is taken on a rising clock edge when `adv_ld_n` is low. When all three active-low selects are also low, the command starts a read (`we_n` high) or a write (`we_n` low). When any select is high, the cycle is a deselect. When `adv_ld_n` is high, the core does not take a new command. It repeats the previous access type at the next address in a four-word wrap.

Reads are flow-through: the addressed word appears on the bus within the cycle that follows the command edge. Write data is taken from the bus one edge after the command. The core turns its bus drivers off whenever write data is expected on the bus, whatever the output enable says, so a controller can go straight from a read to a write without an idle cycle.

Top module: `sram_cio`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, the core leaves `dq` undriven and no access is pending.
- R2: A read command is `adv_ld_n`=0, `en_n`=3'b000 and `we_n`=1, sampled at edge N. With `oe_n` low, the stored word at that address is on `dq` between edge N and edge N+1.
- R3: While `oe_n` is high, the core does not drive `dq`, even in a read data cycle.
- R4: A write command is `adv_ld_n`=0, `en_n`=3'b000 and `we_n`=0, sampled at edge N. At edge N+1 the core takes `dq` and updates lane i (data bits [8i+7:8i] and parity bit 32+i) only when `bw_n[i]` is 0 at that edge. Lanes whose strobe is 1 keep their old contents.
- R5: In the data cycle of a write, the core never drives `dq`, even with `oe_n` low.
- R6: With `adv_ld_n`=0 and any bit of `en_n` high, the cycle that follows performs no access. The core does not drive `dq` in it, and no memory word changes, whatever `we_n` and `bw_n` are.
- R7: With `adv_ld_n`=1 after a read or write, the access type is kept. The address increments in its two low bits and wraps from 3 to 0, while the upper bits are held. `en_n` and `we_n` are ignored.
- R8: With `adv_ld_n`=1 while no access is pending, the core stays idle and leaves `dq` undriven.
- R9: A read of an address in the data cycle of a write to that same address returns the newly written word in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the command state |
| adv_ld_n | input | 1 | Low: load a new command; high: advance the current burst |
| en_n | input | 3 | Active-low selects; all must be low to start an access |
| we_n | input | 1 | Low selects write, high selects read, at command time |
| oe_n | input | 1 | Active-low output enable for the bus drivers |
| addr | input | AW | Word address, taken with the command |
| bw_n | input | 4 | Active-low lane write strobes, taken with write data |
| dq | inout | 36 | Shared data bus: bytes in [31:0], parity bits in [35:32] |

## Verification
The bench builds the core with its default 6-bit address, so the 64 words are small enough for the reference model to track in full. Even with this small depth, a four-beat burst can start at any alignment. This brings within reach the low-bit wrap from 3 to 0 while the upper address bits stay fixed, and a fifth beat that overwrites the first word. The bench drives write data that differs from the stored word while `oe_n` is low, so any driver left on during a write phase shows up on the bus as X.

// File: rtl/sram_cio.sv
module sram_cio #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int BW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_ld_n,
  input  logic [2:0]       en_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] bw_n,
  inout  wire  [LANES*(BW+1)-1:0] dq
);
  localparam int DW    = LANES * BW;
  localparam int WW    = LANES * (BW + 1);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_WR   = 2'd2;

  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [WW-1:0] rd_word;
  logic          drv_en;

  wire load = !adv_ld_n;
  wire sel  = (en_n == 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
    end else if (load) begin
      op_q <= sel ? (we_n ? OP_RD : OP_WR) : OP_IDLE;
      if (sel) addr_q <= addr;
    end else if (op_q != OP_IDLE) begin
      addr_q <= {addr_q[AW-1:2], addr_q[1:0] + 2'd1};
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BW:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (op_q == OP_WR && !bw_n[l])
        lane_mem[addr_q] <= {dq[DW+l], dq[l*BW +: BW]};
    end
    assign rd_word[l*BW +: BW] = lane_mem[addr_q][BW-1:0];
    assign rd_word[DW+l]       = lane_mem[addr_q][BW];
  end

  assign drv_en = (op_q == OP_RD) && !oe_n;
  assign dq     = drv_en ? rd_word : {WW{1'bz}};
endmodule

module sram_cio_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv_ld_n,
  input logic [2:0]    en_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [1:0]    op_q,
  input logic [AW-1:0] addr_q,
  input logic          drv_en
);
  wire cmd_rd  = !adv_ld_n && en_n == 3'b000 && we_n;
  wire cmd_wr  = !adv_ld_n && en_n == 3'b000 && !we_n;
  wire cmd_des = !adv_ld_n && en_n != 3'b000;

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !drv_en && op_q == 2'd0);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> (oe_n || drv_en));

  a_r3_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drv_en);

  a_r5_write_phase_off: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !drv_en);

  a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_des |=> !drv_en && op_q == 2'd0);

  a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ld_n && op_q != 2'd0) |=>
      (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1) &&
      (addr_q[AW-1:2] == $past(addr_q[AW-1:2])) && (op_q == $past(op_q)));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ld_n && op_q == 2'd0) |=> op_q == 2'd0);
endmodule

bind sram_cio sram_cio_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv_ld_n(adv_ld_n), .en_n(en_n), .we_n(we_n),
  .oe_n(oe_n), .op_q(op_q), .addr_q(addr_q), .drv_en(drv_en)
);

// File: tb/tb_sram_cio.sv
module tb_sram_cio;
  localparam int AW = 6;
  localparam int WW = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          adv_ld_n = 1'b1;
  logic [2:0]    en_n = 3'b111;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0]    bw_n = 4'b1111;
  logic          tb_drive = 1'b0;
  logic [WW-1:0] tb_data = '0;
  wire  [WW-1:0] dq;
  assign dq = tb_drive ? tb_data : {WW{1'bz}};

  sram_cio #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .adv_ld_n(adv_ld_n), .en_n(en_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .bw_n(bw_n), .dq(dq)
  );

  logic [WW-1:0] mm [1<<AW];
  int            eop = 0;
  logic [AW-1:0] ea = '0;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  function automatic logic [WW-1:0] pat(input int k);
    return {4'(k * 5 + 3), 32'h5A000000 ^ (32'(k) * 32'h01030507)};
  endfunction

  task automatic step(input logic adv, input logic [2:0] en, input logic we,
                      input logic [AW-1:0] a, input logic [3:0] bw, input logic oe,
                      input logic drv, input logic [WW-1:0] d, input string tag);
    logic [WW-1:0] exp;
    @(negedge clk);
    adv_ld_n = adv; en_n = en; we_n = we; addr = a; bw_n = bw; oe_n = oe;
    tb_drive = drv; tb_data = d;
    #3;
    if (eop == 1 && !oe) exp = mm[ea];
    else if (drv)        exp = d;
    else                 exp = {WW{1'bz}};
    n_tests++;
    if (dq !== exp) begin
      n_fail++;
      $display("FAIL %s: dq=%h expected %h", tag, dq, exp);
    end
    @(posedge clk);
    if (!rst_n) begin
      eop = 0; ea = '0;
    end else begin
      if (eop == 2)
        for (int l = 0; l < 4; l++)
          if (!bw[l]) begin
            mm[ea][l*8 +: 8] = d[l*8 +: 8];
            mm[ea][32+l]     = d[32+l];
          end
      if (!adv) begin
        if (en == 3'b000) begin eop = we ? 1 : 2; ea = a; end
        else eop = 0;
      end else if (eop != 0) begin
        ea[1:0] = ea[1:0] + 2'd1;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) step(1, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R1 reset bus free");
    rst_n = 1'b1;
    repeat (2) step(1, 3'b000, 0, 5, 4'h0, 0, 0, '0, "R8 idle with adv high");

    for (int i = 0; i < 8; i++)
      step(0, 3'b000, 0, AW'(i), (i == 0) ? 4'hF : 4'h0, 0, i > 0,
           (i > 0) ? pat(i - 1) : '0, "R4 R5 full write, drivers off");
    step(0, 3'b000, 1, 0, 4'h0, 0, 1, pat(7), "R5 write phase with oe low");
    for (int i = 1; i < 8; i++)
      step(0, 3'b000, 1, AW'(i), 4'hF, 0, 0, '0, "R2 flow-through read");
    step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R2 last read word");
    step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R6 deselect bus free");

    step(0, 3'b000, 1, 3, 4'hF, 0, 0, '0, "R6 idle before read");
    step(0, 3'b000, 1, 3, 4'hF, 1, 0, '0, "R3 oe high undriven");
    step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R2 read with oe low");
    step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R6 deselect undriven");

    step(0, 3'b000, 0, 2, 4'hF, 0, 0, '0, "R4 masked write cmd");
    step(0, 3'b111, 1, 0, 4'b1010, 0, 1, 36'hF_FFFF_FFFF, "R5 masked write data");
    step(0, 3'b000, 1, 2, 4'hF, 0, 0, '0, "R4 read back cmd");
    step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R4 byte lanes 0 and 2 only");

    for (int k = 0; k < 3; k++) begin
      step(0, 3'(1 << k), 0, 2, 4'hF, 0, 0, '0, "R6 deselected write cmd");
      step(0, 3'b111, 1, 0, 4'h0, 0, 1, '0, "R6 no write from deselect");
      step(0, 3'b000, 1, 2, 4'hF, 0, 0, '0, "R6 read cmd");
      step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R6 word unchanged");
    end

    step(0, 3'b000, 1, 6, 4'hF, 0, 0, '0, "R7 burst read load");
    step(1, 3'b111, 0, 0, 4'hF, 0, 0, '0, "R7 burst beat 6");
    step(1, 3'b111, 0, 0, 4'hF, 0, 0, '0, "R7 burst beat 7");
    step(1, 3'b111, 0, 0, 4'hF, 0, 0, '0, "R7 burst beat 4 wrap");
    step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R7 burst beat 5");

    step(0, 3'b000, 0, 9, 4'hF, 0, 0, '0, "R7 burst write load");
    step(1, 3'b111, 1, 0, 4'h0, 0, 1, pat(20), "R7 burst write 9");
    step(1, 3'b111, 1, 0, 4'h0, 0, 1, pat(21), "R7 burst write 10");
    step(1, 3'b111, 1, 0, 4'h0, 0, 1, pat(22), "R7 burst write 11");
    step(1, 3'b111, 1, 0, 4'b0110, 0, 1, pat(23), "R7 burst write 8 masked");
    step(0, 3'b111, 1, 0, 4'h0, 0, 1, pat(24), "R7 burst write 9 again");
    step(0, 3'b000, 1, 8, 4'hF, 0, 0, '0, "R7 burst read load 8");
    for (int i = 0; i < 3; i++)
      step(1, 3'b000, 0, 0, 4'hF, 0, 0, '0, "R7 burst read back");
    step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R7 burst read back last");

    step(0, 3'b000, 0, 12, 4'hF, 0, 0, '0, "R9 write cmd");
    step(0, 3'b000, 1, 12, 4'h0, 0, 1, pat(30), "R9 data with read cmd");
    step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R9 new word read");

    step(0, 3'b111, 1, 0, 4'hF, 0, 0, '0, "R8 after deselect");
    step(1, 3'b000, 1, 4, 4'hF, 0, 0, '0, "R8 adv high stays idle");
    step(1, 3'b000, 0, 4, 4'h0, 0, 0, '0, "R8 still idle");
    finish_run();
  end
endmodule